// File: doc/BRIEF.md
# Serial Frame Aligner and Word Gearbox

The block sits behind a high-speed receiver. The receiver hands it one 20-bit parallel word per word-clock cycle. The block finds where each 120-bit frame begins in that stream and joins six aligned words into one frame. A frame is sent every 25 ns, in step with a reference of about 40 MHz, so the word clock runs six times faster than the frame rate.

To find the boundary, the block slides its word alignment one bit at a time. It stops when a valid 4-bit header turns up at the same place frame after frame. The block then reports three things:
- the chosen slip count;
- a one-cycle boundary flag on the first word of every frame, which downstream logic can use to phase-adjust a recovered frame clock;
- each completed frame, with a data/filler indication.

The sender emits filler frames whenever it has nothing to carry, so lock holds across idle periods. The 32 check bits at the tail of each frame are passed on unchanged. No error correction is done here.

Top module: `frame_aligner`

## Requirements
- R1: After a synchronous reset, `locked`, `frame_valid` and `hdr_flag` are low, and `slip` and `err_cnt` are zero.
- R2: Bit order and frame layout:
  - The stream is taken MSB first within each word.
  - A frame is 4 header bits, 84 payload bits and 32 check bits, in that order.
  - `frame_out[119]` is the earliest bit received, and the header is `frame_out[119:116]`.
  - Header 4'b0101 marks a data frame and 4'b0110 marks a filler frame. Both are valid, and `frame_is_data` is high only for 4'b0101.
  - The payload and check bits are delivered unchanged.
- R3: `slip` ranges over 0 to 19. With slip s, the aligned word is the 20 stream bits that start s bits after the MSB of the previous input word. Lock is declared on the 8th consecutive valid header seen at the same word position. Once locked, `slip` equals the bit offset of the header within its input word.
- R4: While searching, each slip change is followed by 2 ignored words. After that, 6 consecutive words without a valid header advance `slip` by one, wrapping from 19 to 0.
- R5: While locked, a frame whose header begins in input word n is presented with a one-cycle `frame_valid` in the cycle after input word n+6 is sampled. `frame_valid` is never high while `locked` is low.
- R6: `hdr_flag` pulses for one cycle in the cycle after input word n+1 is sampled, for every accepted frame. It leads that frame's `frame_valid` by exactly 5 cycles.
- R7: While locked, fewer than 4 consecutive invalid headers keep the lock. The 4th consecutive invalid header drops `locked` and advances `slip` by one.
- R8: `err_cnt` counts every invalid header seen while locked, including the one that drops the lock. It saturates at 2^ERR_W-1.
- R9: `err_clr` zeroes `err_cnt` on the next clock edge and takes priority over counting.
- R10: A frame whose header is invalid is never delivered.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Word clock |
| rst | input | 1 | Synchronous reset, active high |
| err_clr | input | 1 | Synchronous clear of the invalid-header counter |
| rx_word | input | WORD_W | Parallel word from the receiver, MSB first in time |
| locked | output | 1 | Frame alignment achieved |
| slip | output | $clog2(WORD_W) | Bit-slip position in use |
| hdr_flag | output | 1 | One-cycle pulse marking the first word of an accepted frame |
| frame_valid | output | 1 | One-cycle strobe for a completed frame |
| frame_is_data | output | 1 | Delivered frame carries data rather than filler |
| frame_out | output | WORD_W*WORDS_PER_FRAME | Assembled frame, earliest bit at the MSB |
| err_cnt | output | ERR_W | Saturating count of invalid headers seen while locked |

## Verification
The stimulus places the frame boundary at bit offsets 0, 1, 7, 13 and 19. Offsets 0 and 19 are the two extremes of the slip range, and 19 makes the header straddle two input words. A shift taken in the wrong direction, or an off-by-one in the alignment window, would lock on the wrong slip or never lock at all. Every delivered frame is compared to the frame sent, together with the input word at which it appears. A gearbox that grouped the wrong six words, or mis-timed the strobe or the boundary flag, would therefore show up as a content or timing mismatch.

The directed part of the bench covers lock retention and loss:
- Runs of exactly three bad headers must keep the lock. A threshold set one too low would drop it.
- A fourth bad header must move the slip exactly one step.
- A further frame must step it again after the settle window and six empty words. A wrong settle or miss count would leave the slip at a different value.

A narrow-counter instance shows saturation, and the clear is checked on both instances.

// File: rtl/frame_aligner.sv
module frame_aligner #(
  parameter int WORD_W          = 20,
  parameter int WORDS_PER_FRAME = 6,
  parameter int HDR_W           = 4,
  parameter int LOCK_FRAMES     = 8,
  parameter int UNLOCK_FRAMES   = 4,
  parameter int SETTLE_WORDS    = 2,
  parameter int ERR_W           = 16,
  parameter logic [HDR_W-1:0] HDR_DATA = 4'b0101,
  parameter logic [HDR_W-1:0] HDR_IDLE = 4'b0110
) (
  input  logic                                clk,
  input  logic                                rst,
  input  logic                                err_clr,
  input  logic [WORD_W-1:0]                   rx_word,
  output logic                                locked,
  output logic [$clog2(WORD_W)-1:0]           slip,
  output logic                                hdr_flag,
  output logic                                frame_valid,
  output logic                                frame_is_data,
  output logic [WORD_W*WORDS_PER_FRAME-1:0]   frame_out,
  output logic [ERR_W-1:0]                    err_cnt
);
  localparam int FW       = WORD_W * WORDS_PER_FRAME;
  localparam int SW       = $clog2(WORD_W);
  localparam int PW       = $clog2(WORDS_PER_FRAME);
  localparam int GW       = $clog2(LOCK_FRAMES + 1);
  localparam int BW       = $clog2(UNLOCK_FRAMES + 1);
  localparam int TW       = $clog2(SETTLE_WORDS + 1);
  localparam int PAIR_TOP = 2 * WORD_W - 1;

  logic [WORD_W-1:0]    prev_q;
  logic [2*WORD_W-1:0]  pair;
  logic [WORD_W-1:0]    aligned;
  logic [HDR_W-1:0]     hdr;
  logic                 hdr_ok;
  logic [FW-WORD_W-1:0] sr;
  logic [PW-1:0]        phase;
  logic [PW-1:0]        miss;
  logic [GW-1:0]        good;
  logic [BW-1:0]        bad;
  logic [TW-1:0]        settle;
  logic                 cur_ok, cur_data;
  logic                 at_start, at_last, lock_now, accept;
  logic [SW-1:0]        next_slip;

  assign pair      = {prev_q, rx_word};
  assign aligned   = pair[PAIR_TOP - int'(slip) -: WORD_W];
  assign hdr       = aligned[WORD_W-1 -: HDR_W];
  assign hdr_ok    = (hdr == HDR_DATA) || (hdr == HDR_IDLE);
  assign at_start  = (phase == '0);
  assign at_last   = (phase == PW'(WORDS_PER_FRAME - 1));
  assign next_slip = (slip == SW'(WORD_W - 1)) ? '0 : slip + 1'b1;
  assign lock_now  = !locked && settle == '0 && good == GW'(LOCK_FRAMES - 1)
                     && at_start && hdr_ok;
  assign accept    = at_start && hdr_ok && (locked || lock_now);

  always_ff @(posedge clk) begin
    if (rst) begin
      prev_q        <= '0;
      sr            <= '0;
      phase         <= '0;
      miss          <= '0;
      good          <= '0;
      bad           <= '0;
      settle        <= '0;
      slip          <= '0;
      locked        <= 1'b0;
      cur_ok        <= 1'b0;
      cur_data      <= 1'b0;
      hdr_flag      <= 1'b0;
      frame_valid   <= 1'b0;
      frame_is_data <= 1'b0;
      frame_out     <= '0;
      err_cnt       <= '0;
    end else begin
      prev_q      <= rx_word;
      sr          <= {sr[FW-2*WORD_W-1:0], aligned};
      phase       <= at_last ? '0 : phase + 1'b1;
      hdr_flag    <= accept;
      frame_valid <= locked && at_last && cur_ok;
      if (at_start) begin
        cur_ok   <= accept;
        cur_data <= (hdr == HDR_DATA);
      end
      if (at_last) begin
        frame_out     <= {sr, aligned};
        frame_is_data <= cur_data;
      end

      if (locked) begin
        if (at_start) begin
          if (hdr_ok) bad <= '0;
          else if (bad == BW'(UNLOCK_FRAMES - 1)) begin
            locked <= 1'b0;
            bad    <= '0;
            good   <= '0;
            miss   <= '0;
            slip   <= next_slip;
            settle <= TW'(SETTLE_WORDS);
          end else bad <= bad + 1'b1;
        end
      end else if (settle != '0) begin
        settle <= settle - 1'b1;
      end else if (good == '0) begin
        if (hdr_ok) begin
          good  <= GW'(1);
          miss  <= '0;
          phase <= PW'(1);
        end else if (miss == PW'(WORDS_PER_FRAME - 1)) begin
          miss   <= '0;
          slip   <= next_slip;
          settle <= TW'(SETTLE_WORDS);
        end else miss <= miss + 1'b1;
      end else if (at_start) begin
        if (hdr_ok) begin
          if (lock_now) begin
            locked <= 1'b1;
            good   <= '0;
            bad    <= '0;
          end else good <= good + 1'b1;
        end else begin
          good   <= '0;
          miss   <= '0;
          slip   <= next_slip;
          settle <= TW'(SETTLE_WORDS);
        end
      end

      if (err_clr) err_cnt <= '0;
      else if (locked && at_start && !hdr_ok && err_cnt != '1) err_cnt <= err_cnt + 1'b1;
    end
  end

  assert_lock_flags_R3: assert property (@(posedge clk) disable iff (rst)
    $rose(locked) |-> hdr_flag);
  assert_valid_needs_lock_R5: assert property (@(posedge clk) disable iff (rst)
    frame_valid |-> locked);
  assert_flag_leads_frame_R6: assert property (@(posedge clk) disable iff (rst)
    frame_valid |-> $past(hdr_flag, 5));
  assert_drop_steps_slip_R7: assert property (@(posedge clk) disable iff (rst)
    $fell(locked) |-> slip == (($past(slip) == SW'(WORD_W - 1)) ? '0 : $past(slip) + 1'b1));
  assert_err_saturates_R8: assert property (@(posedge clk) disable iff (rst)
    (err_cnt == '1 && !err_clr) |=> err_cnt == '1);
  assert_err_clear_R9: assert property (@(posedge clk) disable iff (rst)
    err_clr |=> err_cnt == '0);
  assert_no_bad_frame_R10: assert property (@(posedge clk) disable iff (rst)
    frame_valid |-> (frame_out[FW-1 -: HDR_W] == HDR_DATA || frame_out[FW-1 -: HDR_W] == HDR_IDLE));
endmodule

// File: tb/frame_aligner_bench.sv
module frame_aligner_bench;
  logic clk = 1'b0, rst = 1'b1, err_clr = 1'b0;
  logic [19:0] rx_word = '0;
  logic locked, hdr_flag, frame_valid, frame_is_data;
  logic [4:0] slip;
  logic [119:0] frame_out;
  logic [15:0] err_cnt;
  logic n_locked, n_hdr_flag, n_frame_valid, n_is_data;
  logic [4:0] n_slip;
  logic [119:0] n_frame;
  logic [2:0] n_err;

  always #4 clk = ~clk;

  frame_aligner u_frame_aligner (
    .clk(clk), .rst(rst), .err_clr(err_clr), .rx_word(rx_word),
    .locked(locked), .slip(slip), .hdr_flag(hdr_flag), .frame_valid(frame_valid),
    .frame_is_data(frame_is_data), .frame_out(frame_out), .err_cnt(err_cnt));

  frame_aligner #(.ERR_W(3)) u_narrow (
    .clk(clk), .rst(rst), .err_clr(err_clr), .rx_word(rx_word),
    .locked(n_locked), .slip(n_slip), .hdr_flag(n_hdr_flag), .frame_valid(n_frame_valid),
    .frame_is_data(n_is_data), .frame_out(n_frame), .err_cnt(n_err));

  // offset, pattern seed, expected slip
  localparam int VEC [5][3] = '{'{0, 0, 0}, '{7, 1, 7}, '{13, 2, 13}, '{19, 4, 19}, '{1, 3, 1}};

  int tests = 0, fails = 0;
  bit done = 0;
  logic [119:0] sent [0:511];
  int nsent, cur, seed, delivered;
  logic [159:0] sbuf;
  int nbuf;
  bit clr_pending = 0;
  logic s_locked;
  logic [4:0] s_slip;
  logic [15:0] s_err;
  logic [2:0] s_nerr;

  task automatic check(bit ok, string req, string what, int act, int exp);
    tests++;
    if (!ok) begin
      fails++;
      $display("FAIL %s %s: actual %0d expected %0d", req, what, act, exp);
    end
  endtask

  function automatic logic [119:0] make_frame(int k, int sd, bit bad);
    logic [3:0] h;
    logic [115:0] body;
    int m;
    m = k + sd;
    h = bad ? 4'b0000 : (((m % 5) < 2) ? 4'b0101 : 4'b0110);
    case (m % 3)
      0: body = '0;
      1: body = '1;
      default: body = {29{4'b1110}};
    endcase
    return {h, body};
  endfunction

  task automatic sample();
    int k;
    s_locked = locked; s_slip = slip; s_err = err_cnt; s_nerr = n_err;
    if (hdr_flag) check(cur >= 1 && (cur - 1) % 6 == 0, "R6", "hdr_flag word index mod 6", (cur - 1) % 6, 0);
    if (frame_valid) begin
      delivered++;
      check(cur >= 6 && (cur - 6) % 6 == 0, "R5", "frame_valid word index mod 6", (cur - 6) % 6, 0);
      k = (cur - 6) / 6;
      if (cur >= 6 && k < nsent) begin
        tests++;
        if (frame_out !== sent[k]) begin
          fails++;
          $display("FAIL R2 frame %0d: actual %h expected %h", k, frame_out, sent[k]);
        end
        check(frame_is_data == (sent[k][119:116] == 4'b0101), "R2", "data flag",
              int'(frame_is_data), int'(sent[k][119:116] == 4'b0101));
        check(frame_out[119:116] == 4'b0101 || frame_out[119:116] == 4'b0110, "R10",
              "delivered header", int'(frame_out[119:116]), 5);
      end
    end
  endtask

  task automatic drive(logic [19:0] w);
    @(negedge clk);
    sample();
    rx_word = w;
    err_clr = clr_pending;
    clr_pending = 0;
    cur++;
  endtask

  task automatic push_bits(logic [119:0] f, int n);
    logic [19:0] w;
    sbuf = (sbuf << n) | 160'(f);
    nbuf += n;
    while (nbuf >= 20) begin
      w = 20'(sbuf >> (nbuf - 20));
      nbuf -= 20;
      drive(w);
    end
  endtask

  task automatic send(bit bad);
    logic [119:0] f;
    f = make_frame(nsent, seed, bad);
    sent[nsent] = f;
    nsent++;
    push_bits(f, 120);
  endtask

  task automatic start_run(int off, int sd, bit check_reset);
    @(negedge clk);
    rst = 1; rx_word = '0; err_clr = 0;
    repeat (2) @(negedge clk);
    rst = 0;
    if (check_reset) begin
      check(!locked && !frame_valid && !hdr_flag, "R1", "flags after reset", int'({locked, frame_valid, hdr_flag}), 0);
      check(slip == 0, "R1", "slip after reset", int'(slip), 0);
      check(err_cnt == 0, "R1", "err_cnt after reset", int'(err_cnt), 0);
    end
    cur = -1; nsent = 0; nbuf = 0; sbuf = '0; seed = sd; delivered = 0;
    push_bits('0, off);
  endtask

  initial begin
    for (int i = 0; i < 5; i++) begin
      start_run(VEC[i][0], VEC[i][1], i == 0);
      repeat (60) send(0);
      check(s_locked == 1'b1, "R3", "locked after stream", int'(s_locked), 1);
      check(int'(s_slip) == VEC[i][2], "R3", "slip after lock", int'(s_slip), VEC[i][2]);
      check(delivered >= 15, "R5", "frames delivered", delivered, 15);
    end

    start_run(5, 2, 0);
    repeat (50) send(0);
    check(s_locked == 1'b1 && s_slip == 5, "R3", "lock at offset 5", int'(s_slip), 5);
    for (int r = 0; r < 3; r++) begin
      repeat (3) send(1);
      send(0);
    end
    check(s_locked == 1'b1, "R7", "lock kept over 3-bad runs", int'(s_locked), 1);
    check(s_err == 9, "R8", "err_cnt after 9 bad", int'(s_err), 9);
    check(s_nerr == 7, "R8", "narrow err_cnt saturated", int'(s_nerr), 7);
    clr_pending = 1;
    send(0);
    check(s_err == 0, "R9", "err_cnt cleared", int'(s_err), 0);
    check(s_nerr == 0, "R9", "narrow err_cnt cleared", int'(s_nerr), 0);
    repeat (4) send(1);
    check(s_locked == 1'b0, "R7", "lock lost after 4 bad", int'(s_locked), 0);
    check(s_slip == 6, "R7", "slip stepped on loss", int'(s_slip), 6);
    check(s_err == 4, "R8", "err_cnt counts dropping header", int'(s_err), 4);
    send(0);
    check(s_slip == 7, "R4", "slip after settle and 6 misses", int'(s_slip), 7);
    repeat (50) send(0);
    check(s_locked == 1'b1 && s_slip == 5, "R3", "relock at offset 5", int'(s_slip), 5);

    done = 1;
    $display("[TB] %0d tests run, %0d failed", tests, fails);
    $finish;
  end

  initial begin
    repeat (100000) @(posedge clk);
    if (!done) begin
      tests++;
      fails++;
      $display("FAIL R5 watchdog: actual timeout expected completion");
      $display("[TB] %0d tests run, %0d failed", tests, fails);
      $finish;
    end
  end
endmodule